// File: doc/BRIEF.md
# Compare and Branch Resolution Unit

This execute-stage unit resolves branches for a pipeline that keeps no flags register. A compare operation turns two register operands into a three-way condition code and hands it back as an ordinary register write. A later branch can test that code register against a small mask carried in the instruction. A fused form compares two registers and branches in the same operation. Register reads, fetch, decode and flushing stay outside the block.

Every branch comes with a static prediction bit. The unit returns whether the branch is taken and the target address. It also reports whether the static guess was wrong and how many clocks the branch costs: one clock when the guess holds and four when it does not. All results are registered and appear one clock after a valid request.

Top module: `cmpbr_unit`

## Requirements
- R1: Outputs are registered. `out_valid` is high exactly in the clock after a clock with `in_valid` high. While `rst_n` is low (synchronous reset), `out_valid`, `out_wr_en`, `out_is_branch`, `out_taken`, `out_mispredict` and `out_cost` are cleared.
- R2: `in_op[1:0]`=00 is a compare. It asserts `out_wr_en`, and `out_wr_data` carries a one-hot code in bits [2:0] with all upper bits zero: bit 0 means a<b, bit 1 means a==b, bit 2 means a>b. No other operation asserts `out_wr_en`.
- R3: By default compares are signed two's-complement. When `in_op[2]`=1 the compare (plain or fused) is unsigned.
- R4: `in_op[1:0]`=01 branches on a code register. The code register is `in_a` and the 3-bit constant is `in_mask`. The branch is taken when `in_mask & in_a[2:0]` is nonzero, so mask 110 means greater-or-equal.
- R5: A code register (`in_a`) with any bit above bit 2 set matches no mask, and the branch is not taken.
- R6: `in_op[1:0]`=10 is a fused compare-and-branch. It forms the R2 code from `in_a` and `in_b` and is taken when `in_mask` ANDed with that code is nonzero. It does not write a register.
- R7: For a branch, `out_mispredict` = `out_taken` XOR `in_pred`, and `out_cost` is 1 on a correct guess and 4 on a wrong one. A compare reports cost 1, not taken and no mispredict.
- R8: For a branch, `out_target` is the request's `in_target` whether or not the branch is taken. For any other operation it is zero.
- R9: `in_op[1:0]`=11 is a no-operation. It yields `out_valid` with no write, no branch, no mispredict and cost 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request valid |
| in_op | input | 3 | [1:0] operation kind, [2] unsigned compare |
| in_a | input | W (32) | First operand, or the code register for a branch on code |
| in_b | input | W (32) | Second operand |
| in_mask | input | 3 | Condition mask (bit 0 less, bit 1 equal, bit 2 greater) |
| in_pred | input | 1 | Static prediction, 1 = predicted taken |
| in_target | input | AW (32) | Branch target address |
| out_valid | output | 1 | Result valid |
| out_wr_en | output | 1 | Condition-code register write enable |
| out_wr_data | output | W (32) | Condition code to write |
| out_is_branch | output | 1 | Result belongs to a branch |
| out_taken | output | 1 | Branch taken |
| out_target | output | AW (32) | Target address |
| out_mispredict | output | 1 | Static prediction was wrong |
| out_cost | output | COST_W (3) | Branch cost in clocks |

## Verification
The bench builds the unit with its defaults: 32-bit operands and addresses and costs of 1 and 4. At this width the operands 0x80000000 against 0x7fffffff, and all-ones against one, order one way as signed values and the other way as unsigned values. That exposes a wrong signedness choice in both the plain and the fused compare. The 32-bit code register also allows codes whose stray bits sit just above the code field or at the top bit, which exercises the rule that such a code matches no mask.

// File: rtl/cmpbr_pkg.sv
// Shared types for the compare and branch resolution unit.
// Assumes the operation kind is the low two bits of the opcode.
package cmpbr_pkg;
    localparam int CODE_W = 3;

    typedef enum logic [1:0] {
        OPK_CMP   = 2'b00,
        OPK_BCODE = 2'b01,
        OPK_BFUSE = 2'b10,
        OPK_NOP   = 2'b11
    } op_kind_e;

    typedef struct packed {
        logic gt;
        logic eq;
        logic lt;
    } cc_t;
endpackage

// File: rtl/cmpbr_compare.sv
// Three-way comparator: produces a one-hot {gt, eq, lt} code for two operands.
// Assumes the caller selects signed or unsigned ordering with uns.
module cmpbr_compare
    import cmpbr_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         uns,
    output cc_t          cc
);
    logic lt_s;
    logic lt_u;
    logic same;

    // Form both orderings and pick one; greater is what is neither less nor equal.
    always_comb begin
        lt_s  = $signed(a) < $signed(b);
        lt_u  = a < b;
        same  = (a == b);
        cc.lt = uns ? lt_u : lt_s;
        cc.eq = same;
        cc.gt = ~(uns ? lt_u : lt_s) & ~same;
    end
endmodule

// File: rtl/cmpbr_cond.sv
// Condition tester: matches a register-held code against a 3-bit mask.
// Assumes a code with any bit above the code field set is malformed and never matches.
module cmpbr_cond
    import cmpbr_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]      code,
    input  logic [CODE_W-1:0] mask,
    output logic              match
);
    logic stray;

    // Detect stray upper bits only when the register is wider than the code field.
    generate
        if (W > CODE_W) begin : g_upper
            always_comb stray = |code[W-1:CODE_W];
        end else begin : g_flat
            always_comb stray = 1'b0;
        end
    endgenerate

    // Any shared bit between mask and a well-formed code means a match.
    always_comb match = ~stray & (|(mask & code[CODE_W-1:0]));
endmodule

// File: rtl/cmpbr_resolve.sv
// Prediction check: flags a wrong static guess and prices the operation in clocks.
// Assumes non-branch work costs the hit cost and idle (no-operation) costs zero.
module cmpbr_resolve #(
    parameter int COST_HIT  = 1,
    parameter int COST_MISS = 4,
    parameter int COST_W    = $clog2(COST_MISS + 1)
) (
    input  logic              is_work,
    input  logic              is_branch,
    input  logic              taken,
    input  logic              pred,
    output logic              mispredict,
    output logic [COST_W-1:0] cost
);
    // A branch mispredicts when the outcome differs from the static bit.
    always_comb mispredict = is_branch & (taken ^ pred);

    // Cost follows the prediction outcome for branches; other work is single-clock.
    always_comb begin
        if (!is_work)
            cost = '0;
        else if (mispredict)
            cost = COST_W'(COST_MISS);
        else
            cost = COST_W'(COST_HIT);
    end
endmodule

// File: rtl/cmpbr_unit.sv
// Compare and branch resolution unit (top). Decodes the operation kind, runs the
// comparator and mask test, checks the static prediction and registers all results.
// Assumes W is wider than the 3-bit code field and that operands are already read.
module cmpbr_unit
    import cmpbr_pkg::*;
#(
    parameter int W         = 32,
    parameter int AW        = 32,
    parameter int COST_HIT  = 1,
    parameter int COST_MISS = 4,
    parameter int COST_W    = $clog2(COST_MISS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        in_op,
    input  logic [W-1:0]      in_a,
    input  logic [W-1:0]      in_b,
    input  logic [2:0]        in_mask,
    input  logic              in_pred,
    input  logic [AW-1:0]     in_target,
    output logic              out_valid,
    output logic              out_wr_en,
    output logic [W-1:0]      out_wr_data,
    output logic              out_is_branch,
    output logic              out_taken,
    output logic [AW-1:0]     out_target,
    output logic              out_mispredict,
    output logic [COST_W-1:0] out_cost
);
    localparam int PAD_W = W - CODE_W;

    op_kind_e          kind;
    logic              uns;
    cc_t               cc;
    logic [W-1:0]      cc_word;
    logic [W-1:0]      test_code;
    logic              match;
    logic              is_branch;
    logic              is_work;
    logic              taken;
    logic              miss;
    logic [COST_W-1:0] cost;

    // Split the opcode into kind and signedness select.
    always_comb begin
        kind = op_kind_e'(in_op[1:0]);
        uns  = in_op[2];
    end

    cmpbr_compare #(.W(W)) u_cmp (
        .a   (in_a),
        .b   (in_b),
        .uns (uns),
        .cc  (cc)
    );

    // Widen the fresh code to register width with zero upper bits.
    always_comb cc_word = {{PAD_W{1'b0}}, cc};

    // Branch on code tests the supplied register; the fused form tests the fresh code.
    always_comb test_code = (kind == OPK_BCODE) ? in_a : cc_word;

    cmpbr_cond #(.W(W)) u_cond (
        .code  (test_code),
        .mask  (in_mask),
        .match (match)
    );

    // Classify the operation and decide the branch.
    always_comb begin
        is_branch = (kind == OPK_BCODE) || (kind == OPK_BFUSE);
        is_work   = (kind != OPK_NOP);
        taken     = is_branch & match;
    end

    cmpbr_resolve #(
        .COST_HIT  (COST_HIT),
        .COST_MISS (COST_MISS),
        .COST_W    (COST_W)
    ) u_res (
        .is_work    (is_work),
        .is_branch  (is_branch),
        .taken      (taken),
        .pred       (in_pred),
        .mispredict (miss),
        .cost       (cost)
    );

    // Register the control results; an idle cycle clears them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid      <= 1'b0;
            out_wr_en      <= 1'b0;
            out_is_branch  <= 1'b0;
            out_taken      <= 1'b0;
            out_mispredict <= 1'b0;
            out_cost       <= '0;
        end else begin
            out_valid      <= in_valid;
            out_wr_en      <= in_valid && (kind == OPK_CMP);
            out_is_branch  <= in_valid && is_branch;
            out_taken      <= in_valid && taken;
            out_mispredict <= in_valid && miss;
            out_cost       <= in_valid ? cost : '0;
        end
    end

    // Register the data results for each accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_wr_data <= '0;
            out_target  <= '0;
        end else if (in_valid) begin
            out_wr_data <= cc_word;
            out_target  <= is_branch ? in_target : '0;
        end
    end
endmodule

// File: rtl/cmpbr_unit_chk.sv
// Assertion checker for cmpbr_unit, attached by bind. Observes ports only.
module cmpbr_unit_chk #(
    parameter int W         = 32,
    parameter int AW        = 32,
    parameter int COST_HIT  = 1,
    parameter int COST_MISS = 4,
    parameter int COST_W    = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [2:0]        in_op,
    input logic [W-1:0]      in_a,
    input logic [W-1:0]      in_b,
    input logic              in_pred,
    input logic              out_valid,
    input logic              out_wr_en,
    input logic [W-1:0]      out_wr_data,
    input logic              out_is_branch,
    input logic              out_taken,
    input logic              out_mispredict,
    input logic [COST_W-1:0] out_cost
);
    p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_code_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_wr_en |-> ($onehot(out_wr_data[2:0]) && (out_wr_data[W-1:3] == '0)));

    p_write_not_branch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_wr_en |-> (!out_is_branch && !out_taken));

    p_equal_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op[1:0] == 2'b00 && in_a == in_b) |=> (out_wr_data[2:0] == 3'b010));

    p_upper_not_taken_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op[1:0] == 2'b01 && (in_a[W-1:3] != '0)) |=> !out_taken);

    p_mispredict_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_is_branch) |-> (out_mispredict == (out_taken ^ $past(in_pred))));

    p_cost_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_is_branch) |->
            (out_cost == (out_mispredict ? COST_W'(COST_MISS) : COST_W'(COST_HIT))));

    p_nonbranch_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_is_branch |-> (!out_mispredict && !out_taken));

    // in_b is observed only for completeness of the port view.
    logic unused_b;
    always_comb unused_b = ^in_b;
endmodule

bind cmpbr_unit cmpbr_unit_chk #(
    .W(W), .AW(AW), .COST_HIT(COST_HIT), .COST_MISS(COST_MISS), .COST_W(COST_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid       (in_valid),
    .in_op          (in_op),
    .in_a           (in_a),
    .in_b           (in_b),
    .in_pred        (in_pred),
    .out_valid      (out_valid),
    .out_wr_en      (out_wr_en),
    .out_wr_data    (out_wr_data),
    .out_is_branch  (out_is_branch),
    .out_taken      (out_taken),
    .out_mispredict (out_mispredict),
    .out_cost       (out_cost)
);

// File: tb/tb_cmpbr_unit.sv
`timescale 1ns/1ps
// Directed bench for cmpbr_unit: one task per scenario, each checking its results.
module tb_cmpbr_unit;
    localparam int W  = 32;
    localparam int AW = 32;
    localparam int CW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [2:0]    in_op = '0;
    logic [W-1:0]  in_a = '0;
    logic [W-1:0]  in_b = '0;
    logic [2:0]    in_mask = '0;
    logic          in_pred = 1'b0;
    logic [AW-1:0] in_target = '0;
    logic          out_valid, out_wr_en, out_is_branch, out_taken, out_mispredict;
    logic [W-1:0]  out_wr_data;
    logic [AW-1:0] out_target;
    logic [CW-1:0] out_cost;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    cmpbr_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_a(in_a), .in_b(in_b), .in_mask(in_mask), .in_pred(in_pred),
        .in_target(in_target), .out_valid(out_valid), .out_wr_en(out_wr_en),
        .out_wr_data(out_wr_data), .out_is_branch(out_is_branch),
        .out_taken(out_taken), .out_target(out_target),
        .out_mispredict(out_mispredict), .out_cost(out_cost)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one request at a falling edge; results are sampled one falling edge later.
    task automatic issue(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [2:0] m, input logic p, input logic [AW-1:0] tgt);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
        in_mask = m; in_pred = p; in_target = tgt;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        in_valid = 1'b1; in_op = 3'b001; in_a = 32'd4; in_mask = 3'b100; in_pred = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset out_valid", out_valid, 0);
        chk("R1 reset wr_en", out_wr_en, 0);
        chk("R1 reset taken", out_taken, 0);
        chk("R1 reset cost", out_cost, 0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", out_valid, 0);
    endtask

    task automatic t_compare();
        issue(3'b000, 32'd5, 32'd9, 3'b000, 1'b0, 32'h40);
        chk("R2 less code", out_wr_data, 32'h1);
        chk("R2 write enable", out_wr_en, 1);
        chk("R2 valid", out_valid, 1);
        chk("R7 compare cost", out_cost, 1);
        chk("R7 compare no miss", out_mispredict, 0);
        chk("R8 compare target zero", out_target, 0);
        issue(3'b000, 32'd9, 32'd9, 3'b000, 1'b1, 32'h40);
        chk("R2 equal code", out_wr_data, 32'h2);
        chk("R7 compare not taken", out_taken, 0);
        issue(3'b000, 32'd9, 32'd5, 3'b000, 1'b0, 32'h40);
        chk("R2 greater code", out_wr_data, 32'h4);
        chk("R2 not branch", out_is_branch, 0);
    endtask

    task automatic t_sign();
        issue(3'b000, 32'h8000_0000, 32'h7fff_ffff, 3'b000, 1'b0, 0);
        chk("R3 signed min<max", out_wr_data, 32'h1);
        issue(3'b100, 32'h8000_0000, 32'h7fff_ffff, 3'b000, 1'b0, 0);
        chk("R3 unsigned 8000.. > 7fff..", out_wr_data, 32'h4);
        issue(3'b100, 32'hffff_ffff, 32'h1, 3'b000, 1'b0, 0);
        chk("R3 unsigned all-ones > 1", out_wr_data, 32'h4);
        issue(3'b000, 32'hffff_ffff, 32'h1, 3'b000, 1'b0, 0);
        chk("R3 signed -1 < 1", out_wr_data, 32'h1);
    endtask

    task automatic t_bcode();
        issue(3'b001, 32'h4, 0, 3'b110, 1'b1, 32'h100);
        chk("R4 greater vs ge mask taken", out_taken, 1);
        chk("R2 branch writes nothing", out_wr_en, 0);
        chk("R4 is branch", out_is_branch, 1);
        issue(3'b001, 32'h1, 0, 3'b110, 1'b1, 32'h100);
        chk("R4 less vs ge mask not taken", out_taken, 0);
        issue(3'b001, 32'h2, 0, 3'b010, 1'b1, 32'h100);
        chk("R4 equal vs eq mask taken", out_taken, 1);
        issue(3'b001, 32'h2, 0, 3'b000, 1'b0, 32'h100);
        chk("R4 empty mask not taken", out_taken, 0);
    endtask

    task automatic t_upper();
        issue(3'b001, 32'h0000_0104, 0, 3'b111, 1'b1, 32'h200);
        chk("R5 stray bit 8 not taken", out_taken, 0);
        issue(3'b001, 32'h8000_0002, 0, 3'b111, 1'b1, 32'h200);
        chk("R5 stray top bit not taken", out_taken, 0);
        issue(3'b001, 32'h0000_0008, 0, 3'b111, 1'b1, 32'h200);
        chk("R5 stray bit 3 not taken", out_taken, 0);
    endtask

    task automatic t_fuse();
        issue(3'b010, 32'd7, 32'd3, 3'b100, 1'b1, 32'h300);
        chk("R6 7>3 taken", out_taken, 1);
        chk("R6 no write", out_wr_en, 0);
        issue(3'b010, 32'd3, 32'd7, 3'b100, 1'b0, 32'h300);
        chk("R6 3>7 not taken", out_taken, 0);
        issue(3'b110, 32'hffff_ffff, 32'd1, 3'b100, 1'b1, 32'h300);
        chk("R6 unsigned fused taken", out_taken, 1);
        issue(3'b010, 32'hffff_ffff, 32'd1, 3'b100, 1'b1, 32'h300);
        chk("R6 signed fused not taken", out_taken, 0);
        issue(3'b010, 32'd6, 32'd6, 3'b011, 1'b1, 32'h300);
        chk("R6 le mask on equal taken", out_taken, 1);
    endtask

    task automatic t_pred();
        issue(3'b010, 32'd9, 32'd1, 3'b100, 1'b1, 32'h10);
        chk("R7 taken predicted taken miss", out_mispredict, 0);
        chk("R7 hit cost", out_cost, 1);
        issue(3'b010, 32'd9, 32'd1, 3'b100, 1'b0, 32'h10);
        chk("R7 taken predicted not miss", out_mispredict, 1);
        chk("R7 miss cost", out_cost, 4);
        issue(3'b010, 32'd1, 32'd9, 3'b100, 1'b1, 32'h10);
        chk("R7 not taken predicted taken miss", out_mispredict, 1);
        chk("R7 miss cost again", out_cost, 4);
        issue(3'b010, 32'd1, 32'd9, 3'b100, 1'b0, 32'h10);
        chk("R7 not taken predicted not cost", out_cost, 1);
    endtask

    task automatic t_target();
        issue(3'b001, 32'h1, 0, 3'b100, 1'b0, 32'hdead_beec);
        chk("R8 not-taken branch keeps target", out_target, 32'hdead_beec);
        issue(3'b010, 32'd2, 32'd1, 3'b100, 1'b1, 32'h0000_1234);
        chk("R8 taken branch target", out_target, 32'h0000_1234);
    endtask

    task automatic t_nop();
        issue(3'b011, 32'd5, 32'd5, 3'b111, 1'b1, 32'h55);
        chk("R9 nop valid", out_valid, 1);
        chk("R9 nop no write", out_wr_en, 0);
        chk("R9 nop not branch", out_is_branch, 0);
        chk("R9 nop no miss", out_mispredict, 0);
        chk("R9 nop cost", out_cost, 0);
    endtask

    task automatic t_latency();
        @(negedge clk);
        chk("R1 idle gives no valid", out_valid, 0);
        @(negedge clk);
        in_valid = 1'b1; in_op = 3'b000; in_a = 32'd1; in_b = 32'd2;
        @(negedge clk);
        chk("R1 first of pair", out_wr_data, 32'h1);
        in_op = 3'b000; in_a = 32'd3; in_b = 32'd2;
        @(negedge clk);
        chk("R1 second of pair", out_wr_data, 32'h4);
        chk("R1 back-to-back valid", out_valid, 1);
        in_valid = 1'b0;
        @(negedge clk);
        chk("R1 valid drops", out_valid, 0);
    endtask

    initial begin
        t_reset();
        t_compare();
        t_sign();
        t_bcode();
        t_upper();
        t_fuse();
        t_pred();
        t_target();
        t_nop();
        t_latency();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule